// File: doc/BRIEF.md
# Device Interrupt Pin Mapper

This block turns a device's slot number and its interrupt pin (INTA to INTD) into the index of one of eight shared interrupt lines, PIRQ A to H (index 0 to 7). The lookup is purely combinational: present a slot and a pin, and the PIRQ index appears at the output in the same cycle. A later stage routes the shared lines to interrupt controllers. That stage is not part of this block.

Seven slots, starting at slot 25, have a 16-bit route register. Each register holds one 4-bit field per pin. The slot at offset five of that group (slot 30) is hardwired: its register always reads as zero, and its pins always go to PIRQ E to H. Every other slot uses a fixed rotation that only reaches PIRQ E to H. Software programs the route registers through a 16 KiB little-endian window. The window is reached over a request/response bus with valid/ready handshakes. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is held waiting for `rsp_ready`. The response to each accepted request appears on the following cycle and stays stable until `rsp_ready` takes it.

Top module: `irq_pin_mapper`

## Requirements
- R1: After reset, every programmable route register reads 0x3210. The slot-30 register and every other offset in the window read zero.
- R2: For a programmable slot other than 30, pin n (0 = INTA to 3 = INTD) uses the field in bits [4n+3:4n] of that slot's register. Bits [2:0] of that field give the PIRQ index, and bit 3 is stored but ignored.
- R3: Slot 30 always maps pin n to PIRQ index 4+n. Its register, at offsets 0x00A and 0x00B, reads zero and ignores writes.
- R4: Any slot outside 25 to 31 maps pin n of slot s to PIRQ index ((s+n) mod 4)+4.
- R5: A write to a route register changes the lookup output in the first cycle after the write is accepted.
- R6: Only the low 14 bits of `req_addr` are used. Higher address bits have no effect.
- R7: An access that would pass the end of the window (offset 0x3FFF) is cut short at the end. Bytes beyond the end are neither written nor wrapped to offset 0, and they read as zero.
- R8: Data is little-endian. Size code 0 is a byte, 1 is a 16-bit word, and 2 or 3 is a 32-bit dword. The register for slot s is at byte offset 2*(s-25). Accesses may be unaligned.
- R9: Offsets above 0x00D read zero and ignore writes.
- R10: A response follows every accepted request in the next cycle. `req_ready` is high whenever no response is waiting. A waiting response and its data stay stable until `rsp_ready` is high, and no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_slot | input | 5 | Slot number for the lookup |
| lk_pin | input | 2 | Interrupt pin, 0 = INTA to 3 = INTD |
| lk_pirq | output | 3 | PIRQ index, 0 = A to 7 = H |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; only the low 14 bits are used |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data, zero for writes |

## Verification
The checker watches the bus handshake on every cycle. It checks that a response follows each accepted request, that a held response keeps its data, and that no response appears without a request. It also checks on every cycle that slot 30 and the slots outside the programmable range produce the fixed mappings. Only the bench scenarios can show the effects that depend on the values stored in the window: reset contents, field selection, unaligned byte lanes, address masking, truncation at the window end, and writes that must be ignored.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;
  localparam int SLOT_W  = 5;
  localparam int PIN_W   = 2;
  localparam int PIRQ_W  = 3;
  localparam int FIELD_W = 4;
  localparam int ROUTE_W = FIELD_W * (1 << PIN_W);
  localparam int LEN_W   = 3;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  function automatic logic [LEN_W-1:0] size_to_len(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return LEN_W'(1);
      SZ_WORD: return LEN_W'(2);
      default: return LEN_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/irqmap_route_bank.sv
module irqmap_route_bank
  import irqmap_pkg::*;
#(
  parameter int WIN_AW    = 14,
  parameter int NUM_REGS  = 7,
  parameter int HARD_IDX  = 5,
  parameter int BUS_BYTES = 4,
  parameter logic [ROUTE_W-1:0] RST_VAL = 16'h3210
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [WIN_AW-1:0]           acc_addr,
  input  logic [LEN_W-1:0]            acc_len,
  input  logic [BUS_BYTES*8-1:0]      acc_wdata,
  output logic [BUS_BYTES*8-1:0]      acc_rdata,
  output logic [NUM_REGS*ROUTE_W-1:0] route_flat
);
  localparam int REG_BYTES  = ROUTE_W / 8;
  localparam int BANK_BYTES = NUM_REGS * REG_BYTES;

  function automatic logic [BANK_BYTES*8-1:0] reset_image();
    logic [BANK_BYTES*8-1:0] img;
    img = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (r != HARD_IDX) img[r*ROUTE_W +: ROUTE_W] = RST_VAL;
    return img;
  endfunction

  logic [BANK_BYTES*8-1:0] bank_q;
  logic [WIN_AW:0]         lane_off [BUS_BYTES];
  logic [BUS_BYTES-1:0]    lane_hit;

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign lane_off[i] = {1'b0, acc_addr} + (WIN_AW+1)'(i);
    assign lane_hit[i] = (LEN_W'(i) < acc_len) && !lane_off[i][WIN_AW]
                         && (lane_off[i] < (WIN_AW+1)'(BANK_BYTES));
    always_comb begin
      acc_rdata[i*8 +: 8] = 8'h00;
      for (int b = 0; b < BANK_BYTES; b++)
        if (lane_hit[i] && lane_off[i] == (WIN_AW+1)'(b))
          acc_rdata[i*8 +: 8] = bank_q[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= reset_image();
    end else if (wr_en) begin
      for (int b = 0; b < BANK_BYTES; b++)
        if ((b / REG_BYTES) != HARD_IDX)
          for (int i = 0; i < BUS_BYTES; i++)
            if (lane_hit[i] && lane_off[i] == (WIN_AW+1)'(b))
              bank_q[b*8 +: 8] <= acc_wdata[i*8 +: 8];
    end
  end

  assign route_flat = bank_q;
endmodule

// File: rtl/irqmap_pin_lookup.sv
module irqmap_pin_lookup
  import irqmap_pkg::*;
#(
  parameter int FIRST_SLOT = 25,
  parameter int NUM_REGS   = 7,
  parameter int HARD_IDX   = 5
) (
  input  logic [SLOT_W-1:0]           slot,
  input  logic [PIN_W-1:0]            pin,
  input  logic [NUM_REGS*ROUTE_W-1:0] route_flat,
  output logic [PIRQ_W-1:0]           pirq
);
  localparam int LAST_SLOT = FIRST_SLOT + NUM_REGS - 1;

  logic [PIN_W-1:0] rot;
  assign rot = slot[PIN_W-1:0] + pin;

  always_comb begin
    pirq = {1'b1, rot};
    if (int'(slot) >= FIRST_SLOT && int'(slot) <= LAST_SLOT) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (int'(slot) == FIRST_SLOT + r) begin
          if (r == HARD_IDX)
            pirq = {1'b1, pin};
          else
            pirq = route_flat[r*ROUTE_W + int'(pin)*FIELD_W +: PIRQ_W];
        end
      end
    end
  end
endmodule

// File: rtl/irqmap_bus_port.sv
module irqmap_bus_port
  import irqmap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WIN_AW    = 14,
  parameter int BUS_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  input  logic [BUS_BYTES*8-1:0] req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [BUS_BYTES*8-1:0] rsp_rdata,
  output logic                   wr_en,
  output logic [WIN_AW-1:0]      acc_addr,
  output logic [LEN_W-1:0]       acc_len,
  output logic [BUS_BYTES*8-1:0] acc_wdata,
  input  logic [BUS_BYTES*8-1:0] acc_rdata
);
  logic accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write;
  assign acc_addr  = req_addr[WIN_AW-1:0];
  assign acc_len   = size_to_len(req_size);
  assign acc_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : acc_rdata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_pin_mapper.sv
module irq_pin_mapper
  import irqmap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIN_AW     = 14,
  parameter int FIRST_SLOT = 25,
  parameter int NUM_REGS   = 7,
  parameter int HARD_SLOT  = 30,
  parameter logic [15:0] ROUTE_RST = 16'h3210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        lk_slot,
  input  logic [1:0]        lk_pin,
  output logic [2:0]        lk_pirq,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata
);
  localparam int HARD_IDX  = HARD_SLOT - FIRST_SLOT;
  localparam int BUS_BYTES = 4;

  logic                        wr_en;
  logic [WIN_AW-1:0]           acc_addr;
  logic [LEN_W-1:0]            acc_len;
  logic [31:0]                 acc_wdata;
  logic [31:0]                 acc_rdata;
  logic [NUM_REGS*ROUTE_W-1:0] route_flat;

  irqmap_bus_port #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .BUS_BYTES(BUS_BYTES)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wr_en(wr_en), .acc_addr(acc_addr), .acc_len(acc_len),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
  );

  irqmap_route_bank #(.WIN_AW(WIN_AW), .NUM_REGS(NUM_REGS), .HARD_IDX(HARD_IDX),
                      .BUS_BYTES(BUS_BYTES), .RST_VAL(ROUTE_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .route_flat(route_flat)
  );

  irqmap_pin_lookup #(.FIRST_SLOT(FIRST_SLOT), .NUM_REGS(NUM_REGS),
                      .HARD_IDX(HARD_IDX)) u_lookup (
    .slot(lk_slot), .pin(lk_pin), .route_flat(route_flat), .pirq(lk_pirq)
  );
endmodule

// File: rtl/irq_pin_mapper_chk.sv
module irq_pin_mapper_chk #(
  parameter int FIRST_SLOT = 25,
  parameter int HARD_SLOT  = 30
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  lk_slot,
  input logic [1:0]  lk_pin,
  input logic [2:0]  lk_pirq,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata
);
  AST_HARD_SLOT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lk_slot) == HARD_SLOT) |-> (lk_pirq == {1'b1, lk_pin})); // R3

  AST_ROTATE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lk_slot) < FIRST_SLOT) |-> (lk_pirq[2] && lk_pirq[1:0] == 2'(lk_slot[1:0] + lk_pin))); // R4

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && !(rsp_valid && !rsp_ready)) |=> !rsp_valid); // R10

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R10
endmodule

bind irq_pin_mapper irq_pin_mapper_chk #(.FIRST_SLOT(FIRST_SLOT), .HARD_SLOT(HARD_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
);

// File: tb/irq_pin_mapper_test.sv
`timescale 1ns/1ps
module irq_pin_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_pirq;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int errors = 0;
  int checks = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  irq_pin_mapper uut (
    .clk(clk), .rst_n(rst_n), .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  // {slot, pin, expected pirq} after reset
  localparam logic [9:0] VEC [9] = '{
    {5'd25, 2'd0, 3'd0}, {5'd25, 2'd3, 3'd3}, {5'd30, 2'd0, 3'd4},
    {5'd30, 2'd3, 3'd7}, {5'd0,  2'd0, 3'd4}, {5'd3,  2'd2, 3'd5},
    {5'd24, 2'd3, 3'd7}, {5'd31, 2'd1, 3'd1}, {5'd10, 2'd1, 3'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rdo);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    rdo = rsp_rdata;
  endtask

  task automatic look(input logic [4:0] s, input logic [1:0] p, input logic [2:0] exp,
                      input string req);
    lk_slot = s; lk_pin = p;
    #1;
    check(req, 32'(lk_pirq), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset idle", {30'd0, rsp_valid, req_ready}, 32'h1);

    foreach (VEC[k]) begin
      @(negedge clk);
      look(VEC[k][9:5], VEC[k][4:3], VEC[k][2:0], "R1/R2/R3/R4 table");
    end

    // R1 reset contents
    access(1'b0, 32'h0, 2'd1, 32'h0, rd); check("R1 slot25 reset", rd, 32'h3210);
    access(1'b0, 32'hA, 2'd1, 32'h0, rd); check("R3 slot30 reads zero", rd, 32'h0);
    access(1'b0, 32'h200, 2'd2, 32'h0, rd); check("R1 other offset zero", rd, 32'h0);

    // R5 write then lookup on the next cycle
    access(1'b1, 32'h4, 2'd1, 32'h7654, rd);
    look(5'd27, 2'd0, 3'd4, "R5 slot27 INTA after write");
    look(5'd27, 2'd3, 3'd7, "R5 slot27 INTD after write");

    // R2 bit 3 ignored in lookup but stored
    access(1'b1, 32'h4, 2'd0, 32'h9E, rd);
    look(5'd27, 2'd0, 3'd6, "R2 field low bits INTA");
    look(5'd27, 2'd1, 3'd1, "R2 field low bits INTB");
    access(1'b0, 32'h4, 2'd1, 32'h0, rd); check("R2 field stored", rd, 32'h769E);

    // R3 dword over slot29/slot30: slot30 ignores write
    access(1'b1, 32'h8, 2'd2, 32'hAAAA5555, rd);
    access(1'b0, 32'h8, 2'd2, 32'h0, rd); check("R3 slot30 write ignored", rd, 32'h00005555);
    look(5'd30, 2'd2, 3'd6, "R3 slot30 fixed after write");
    look(5'd29, 2'd2, 3'd5, "R2 slot29 INTC");

    // R8 byte lane, little-endian
    access(1'b1, 32'hD, 2'd0, 32'h12, rd);
    access(1'b0, 32'hC, 2'd1, 32'h0, rd); check("R8 high byte write", rd, 32'h1210);
    look(5'd31, 2'd3, 3'd1, "R8 slot31 INTD");

    // R6 address masking
    access(1'b1, 32'h4000_0002, 2'd1, 32'h4444, rd);
    access(1'b0, 32'h2, 2'd1, 32'h0, rd); check("R6 masked address write", rd, 32'h4444);
    look(5'd26, 2'd2, 3'd4, "R6 slot26 INTC");

    // R8 unaligned dword read: bytes 1..4
    access(1'b0, 32'h1, 2'd3, 32'h0, rd); check("R8 unaligned dword", rd, 32'h9E444432);

    // R7 truncation at window end
    access(1'b1, 32'h3FFE, 2'd2, 32'hFFFFFFFF, rd);
    access(1'b0, 32'h0, 2'd1, 32'h0, rd); check("R7 no wrap on write", rd, 32'h3210);
    look(5'd25, 2'd1, 3'd1, "R7 slot25 lookup intact");
    access(1'b0, 32'hFFFF_FFFE, 2'd2, 32'h0, rd); check("R7 read past end zero", rd, 32'h0);

    // R9 unimplemented offsets
    access(1'b1, 32'h100, 2'd2, 32'hDEADBEEF, rd);
    access(1'b0, 32'h100, 2'd2, 32'h0, rd); check("R9 unimplemented reads zero", rd, 32'h0);
    access(1'b1, 32'hE, 2'd1, 32'hFFFF, rd);
    access(1'b0, 32'hC, 2'd2, 32'h0, rd); check("R9 write beyond bank ignored", rd, 32'h00001210);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0; req_size = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp valid", {31'd0, rsp_valid}, 32'h1);
    check("R10 ready low while held", {31'd0, req_ready}, 32'h0);
    @(negedge clk);
    check("R10 held data", rsp_rdata, 32'h3210);
    check("R10 still valid", {31'd0, rsp_valid}, 32'h1);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 released", {30'd0, rsp_valid, req_ready}, 32'h1);

    // R1 reset again restores defaults
    access(1'b1, 32'h0, 2'd1, 32'h0000, rd);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 32'h0, 2'd2, 32'h0, rd); check("R1 reset restores", rd, 32'h32103210);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule